// File: doc/BRIEF.md
# Low-Power Wake-Up Event Timer

This block is a small memory-mapped timer intended to stay powered while processor cores are stopped, so that it can wake them on a programmed delay. A 16-bit counter advances on ticks from a power-of-two prescaler. When the counter reaches the programmed reload value, it returns to zero on that tick and raises a wrap flag. The wrap flag, gated by its interrupt enable, drives a level interrupt line. The line stays high until software clears the flag.

Software talks to the block through a plain write strobe with a byte address and write data, and reads through a combinational read port selected by the same address. Six word registers are mapped: status (offset 0x00), flag clear (0x04), interrupt enable (0x08), configuration (0x0C), control (0x10) and reload (0x14). A run begins with a start command written to the control register together with the enable bit. A run can be single, which stops after one wrap, or looping, which wraps again and again. Register writes are gated by the enable state: the interrupt enable can only change while the timer is off, and the reload value can only change while it is on.

Top module: `lpt_event_timer`

## Requirements
- R1: After reset, status, control, interrupt enable and configuration read 0, reload reads 0xFFFF and irq_o is 0.
- R2: Bit 1 of the interrupt-enable register stores the wrap interrupt enable. A write to this register is accepted only while the enable bit is 0; otherwise it is ignored and the old value is kept. All other bits read 0.
- R3: The reload register (bits 15:0) takes a write only while the enable bit is 1 and only when the written value is non-zero; any other write is ignored. Each accepted reload write sets the reload-updated flag, status bit 4.
- R4: Configuration bits 11:9 hold a divider exponent P from 0 to 7. While running, the counter advances once every 2^P clock cycles.
- R5: After a start command is captured on clock edge E, the counter counts ticks from 0. On the tick at which the count equals the reload value R, the count returns to 0 and the wrap flag (status bit 1) is set, first at edge E + (R+1)*2^P.
- R6: Control bit 2 written with bit 0 starts a looping run. The wrap flag is set again every (R+1)*2^P cycles, and a start command restarts the count from 0 even if a run is already in progress.
- R7: Control bit 1 written with bit 0 starts a single run that stops after its first wrap; the enable bit stays 1.
- R8: When bits 1 and 2 are both written with bit 0, the looping run takes priority.
- R9: Control bit 0 is the enable and reads back at bit 0. Start bits written with bit 0 clear are ignored. Clearing the enable stops the count, resets it to 0 and cancels the run, while the flags keep their values.
- R10: In the clear register, writing 1 to bit 1 clears the wrap flag and writing 1 to bit 4 clears the reload-updated flag; bits written 0 leave their flag alone. Status bit 3 (compare-done) always reads 0. If a flag is set and cleared in the same cycle, the set wins.
- R11: irq_o is high exactly while the wrap flag and its enable are both 1, and it stays high until the flag is cleared or the enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per asserted cycle |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level wake-up interrupt |

## Verification
The embedded properties assume that the bus inputs are known from reset onward, that addresses are word aligned, and that the divider exponent changes only between runs; the tick-spacing property allows for a change, but the period rules do not. The stimulus writes one register per two cycles, programs the configuration only while the timer is disabled, and checks each match period at the exact cycle before and at the expected wrap. Gated writes are checked by reading the register back through the read port after the rejected write. Cancelled and single runs are checked by watching the status flag stay clear over several expected periods.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

   // Register byte offsets
   localparam int unsigned OFS_STATUS = 'h00;
   localparam int unsigned OFS_CLEAR  = 'h04;
   localparam int unsigned OFS_IRQEN  = 'h08;
   localparam int unsigned OFS_CONFIG = 'h0C;
   localparam int unsigned OFS_CTRL   = 'h10;
   localparam int unsigned OFS_RELOAD = 'h14;

   // Control bits
   localparam int unsigned CTL_ENABLE = 0;
   localparam int unsigned CTL_ONCE   = 1;
   localparam int unsigned CTL_LOOP   = 2;

   // Status / clear bits
   localparam int unsigned FLG_WRAP    = 1;
   localparam int unsigned FLG_CMPDONE = 3;
   localparam int unsigned FLG_RLDDONE = 4;

   // Interrupt enable bit
   localparam int unsigned IEN_WRAP = 1;

   typedef enum logic [1:0] {
      RUN_IDLE = 2'd0,
      RUN_ONCE = 2'd1,
      RUN_LOOP = 2'd2
   } run_mode_e;

endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
   parameter int unsigned PSC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic             tick_o
);

   localparam int unsigned DIV_W = (1 << PSC_W) - 1;

   logic [DIV_W-1:0] pre_q;
   logic [DIV_W-1:0] mask;

   // Low P bits of the mask are ones: tick when those bits of pre_q are all ones
   generate
      for (genvar i = 0; i < DIV_W; i++) begin : g_mask
         assign mask[i] = (psc_i > PSC_W'(i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run_i || restart_i) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   assign tick_o = run_i && !restart_i && ((pre_q & mask) == mask);

   // With a divider above 1, two ticks never fall on adjacent cycles
   a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && psc_i != '0) |=> (!tick_o || psc_i == '0));

endmodule

// File: rtl/lpt_counter.sv
module lpt_counter
   import lpt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             start_i,
   input  logic             loop_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             run_o,
   output logic             match_o
);

   run_mode_e        mode_q;
   logic [CNT_W-1:0] count_q;
   logic             at_reload;

   assign at_reload = (count_q == reload_i);
   assign run_o     = (mode_q != RUN_IDLE);
   assign match_o   = run_o && enable_i && tick_i && !start_i && at_reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= RUN_IDLE;
         count_q <= '0;
      end else if (start_i) begin
         mode_q  <= loop_i ? RUN_LOOP : RUN_ONCE;
         count_q <= '0;
      end else if (!enable_i) begin
         mode_q  <= RUN_IDLE;
         count_q <= '0;
      end else if (run_o && tick_i) begin
         if (at_reload) begin
            count_q <= '0;
            if (mode_q == RUN_ONCE) begin
               mode_q <= RUN_IDLE;
            end
         end else begin
            count_q <= count_q + 1'b1;
         end
      end
   end

   a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_i && !start_i) |=> (count_q == '0 && mode_q == RUN_IDLE));

   a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> (count_q == '0));

   a_r7_once_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && mode_q == RUN_ONCE) |=> (mode_q == RUN_IDLE));

   a_r6_loop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && mode_q == RUN_LOOP) |=> (mode_q == RUN_LOOP));

endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
   import lpt_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PSC_W   = 3,
   parameter int unsigned PSC_LSB = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              match_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              enable_o,
   output logic              start_o,
   output logic              loop_o,
   output logic [PSC_W-1:0]  psc_o,
   output logic [CNT_W-1:0]  reload_o,
   output logic              irq_o
);

   logic             sel_clear, sel_irqen, sel_config, sel_ctrl, sel_reload;
   logic             enable_q, ien_q, wrap_q, rld_done_q;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] reload_q;
   logic             ien_take, rld_take, clr_wrap, clr_rld;
   logic             unused_wdata;

   assign sel_clear  = wr_i && (addr_i == ADDR_W'(OFS_CLEAR));
   assign sel_irqen  = wr_i && (addr_i == ADDR_W'(OFS_IRQEN));
   assign sel_config = wr_i && (addr_i == ADDR_W'(OFS_CONFIG));
   assign sel_ctrl   = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
   assign sel_reload = wr_i && (addr_i == ADDR_W'(OFS_RELOAD));

   // Write-permission gating
   assign ien_take = sel_irqen && !enable_q;
   assign rld_take = sel_reload && enable_q && (wdata_i[CNT_W-1:0] != '0);
   assign clr_wrap = sel_clear && wdata_i[FLG_WRAP];
   assign clr_rld  = sel_clear && wdata_i[FLG_RLDDONE];

   // Start command only together with the enable bit
   assign start_o = sel_ctrl && wdata_i[CTL_ENABLE] &&
                    (wdata_i[CTL_ONCE] || wdata_i[CTL_LOOP]);
   assign loop_o  = wdata_i[CTL_LOOP];

   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q   <= 1'b0;
         ien_q      <= 1'b0;
         psc_q      <= '0;
         reload_q   <= '1;
         wrap_q     <= 1'b0;
         rld_done_q <= 1'b0;
      end else begin
         if (sel_ctrl) begin
            enable_q <= wdata_i[CTL_ENABLE];
         end
         if (ien_take) begin
            ien_q <= wdata_i[IEN_WRAP];
         end
         if (sel_config) begin
            psc_q <= wdata_i[PSC_LSB +: PSC_W];
         end
         if (rld_take) begin
            reload_q <= wdata_i[CNT_W-1:0];
         end
         // Set wins over clear
         if (match_i) begin
            wrap_q <= 1'b1;
         end else if (clr_wrap) begin
            wrap_q <= 1'b0;
         end
         if (rld_take) begin
            rld_done_q <= 1'b1;
         end else if (clr_rld) begin
            rld_done_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(OFS_STATUS)) begin
         rdata_o[FLG_WRAP]    = wrap_q;
         rdata_o[FLG_CMPDONE] = 1'b0;
         rdata_o[FLG_RLDDONE] = rld_done_q;
      end else if (addr_i == ADDR_W'(OFS_IRQEN)) begin
         rdata_o[IEN_WRAP] = ien_q;
      end else if (addr_i == ADDR_W'(OFS_CONFIG)) begin
         rdata_o[PSC_LSB +: PSC_W] = psc_q;
      end else if (addr_i == ADDR_W'(OFS_CTRL)) begin
         rdata_o[CTL_ENABLE] = enable_q;
      end else if (addr_i == ADDR_W'(OFS_RELOAD)) begin
         rdata_o[CNT_W-1:0] = reload_q;
      end
   end

   assign enable_o = enable_q;
   assign psc_o    = psc_q;
   assign reload_o = reload_q;
   assign irq_o    = wrap_q && ien_q;

   a_r2_ien_locked: assert property (@(posedge clk) disable iff (!rst_n)
      enable_q |=> $stable(ien_q));

   a_r3_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_q |=> $stable(reload_q));

   a_r3_reload_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      reload_q != '0);

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      match_i |=> wrap_q);

   a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(clr_wrap || ien_take));

endmodule

// File: rtl/lpt_event_timer.sv
module lpt_event_timer #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PSC_W   = 3,
   parameter int unsigned PSC_LSB = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   // Elaboration-time parameter checks
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("lpt_event_timer: CNT_W out of range");
      end
      if (PSC_W < 1 || PSC_W > 4) begin : g_bad_psc
         $error("lpt_event_timer: PSC_W must be 1..4");
      end
      if (PSC_LSB + PSC_W > DATA_W) begin : g_bad_field
         $error("lpt_event_timer: divider field exceeds data width");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("lpt_event_timer: ADDR_W too small for register map");
      end
   endgenerate

   logic             enable, start, loop_sel, run, tick, match;
   logic [PSC_W-1:0] psc;
   logic [CNT_W-1:0] reload;

   lpt_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .PSC_W  (PSC_W),
      .PSC_LSB(PSC_LSB)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr),
      .addr_i  (bus_addr),
      .wdata_i (bus_wdata),
      .match_i (match),
      .rdata_o (bus_rdata),
      .enable_o(enable),
      .start_o (start),
      .loop_o  (loop_sel),
      .psc_o   (psc),
      .reload_o(reload),
      .irq_o   (irq_o)
   );

   lpt_prescaler #(
      .PSC_W(PSC_W)
   ) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .restart_i(start),
      .psc_i    (psc),
      .tick_o   (tick)
   );

   lpt_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable_i(enable),
      .start_i (start),
      .loop_i  (loop_sel),
      .tick_i  (tick),
      .reload_i(reload),
      .run_o   (run),
      .match_o (match)
   );

endmodule

// File: tb/sim_lpt_event_timer.sv
`timescale 1ns/1ps
module sim_lpt_event_timer;

   localparam logic [4:0] A_STAT = 5'h00;
   localparam logic [4:0] A_CLR  = 5'h04;
   localparam logic [4:0] A_IEN  = 5'h08;
   localparam logic [4:0] A_CFG  = 5'h0C;
   localparam logic [4:0] A_CTL  = 5'h10;
   localparam logic [4:0] A_RLD  = 5'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // Scoreboard queues
   bit          kind_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   lpt_event_timer u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq_o    (irq_o)
   );

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_addr = a;
      kind_q.push_back(1'b0); exp_q.push_back(e); tag_q.push_back(tag);
   endtask

   task automatic expect_irq(input logic e, input string tag);
      @(negedge clk);
      kind_q.push_back(1'b1); exp_q.push_back({31'b0, e}); tag_q.push_back(tag);
   endtask

   // Monitor: compares after the driver has settled the read address
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            bit          k;
            logic [31:0] e;
            logic [31:0] act;
            string       t;
            k = kind_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
            act = k ? {31'b0, irq_o} : bus_rdata;
            checks++;
            if (act !== e) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", t, act, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;

      // R1 reset values
      expect_reg(A_STAT, 32'h0, "R1 status");
      expect_reg(A_CTL, 32'h0, "R1 control");
      expect_reg(A_IEN, 32'h0, "R1 irq enable");
      expect_reg(A_CFG, 32'h0, "R1 config");
      expect_reg(A_RLD, 32'h0000_FFFF, "R1 reload");
      expect_irq(1'b0, "R1 irq");

      // R2 enable writable while disabled, other bits read 0
      wr(A_IEN, 32'hFFFF_FFFF);
      expect_reg(A_IEN, 32'h2, "R2 write while off");
      // R3 reload ignored while disabled
      wr(A_RLD, 32'h5);
      expect_reg(A_RLD, 32'h0000_FFFF, "R3 reload locked while off");
      expect_reg(A_STAT, 32'h0, "R3 no update flag");

      wr(A_CFG, 32'h0);
      wr(A_CTL, 32'h1);
      expect_reg(A_CTL, 32'h1, "R9 enable readback");
      // R2 ignored while enabled
      wr(A_IEN, 32'h0);
      expect_reg(A_IEN, 32'h2, "R2 locked while on");
      // R3 accepted while enabled, zero ignored
      wr(A_RLD, 32'h5);
      expect_reg(A_RLD, 32'h5, "R3 reload accepted");
      expect_reg(A_STAT, 32'h10, "R3 update flag");
      wr(A_RLD, 32'h0);
      expect_reg(A_RLD, 32'h5, "R3 zero ignored");
      wr(A_CLR, 32'h18);
      expect_reg(A_STAT, 32'h0, "R10 clear update flag");

      // R5/R6 looping run, R=5 P=0: wraps every 6 cycles
      wr(A_CTL, 32'h5);
      idle(4);
      expect_reg(A_STAT, 32'h0, "R5 before first wrap");
      expect_reg(A_STAT, 32'h2, "R5 first wrap");
      expect_irq(1'b1, "R11 irq high");
      wr(A_CLR, 32'h2);
      expect_irq(1'b0, "R11 irq cleared");
      expect_reg(A_STAT, 32'h0, "R6 before second wrap");
      expect_reg(A_STAT, 32'h2, "R6 second wrap");
      wr(A_CLR, 32'h10);
      expect_reg(A_STAT, 32'h2, "R10 zero bit keeps wrap flag");

      // R9 disable keeps flags, stops run
      wr(A_CTL, 32'h0);
      expect_reg(A_CTL, 32'h0, "R9 disabled");
      expect_reg(A_STAT, 32'h2, "R9 flag kept on disable");
      wr(A_CLR, 32'h2);
      idle(20);
      expect_reg(A_STAT, 32'h0, "R9 no wrap while off");
      wr(A_CTL, 32'h4);
      expect_reg(A_CTL, 32'h0, "R9 start without enable ignored");
      idle(10);
      expect_reg(A_STAT, 32'h0, "R9 no run from ignored start");
      wr(A_CTL, 32'h1);
      idle(20);
      expect_reg(A_STAT, 32'h0, "R9 enable alone does not run");

      // R6 restart from zero during a run
      wr(A_CTL, 32'h5);
      idle(1);
      wr(A_CTL, 32'h5);
      idle(4);
      expect_reg(A_STAT, 32'h0, "R6 restart delays wrap");
      expect_reg(A_STAT, 32'h2, "R6 wrap after restart");
      wr(A_CLR, 32'h2);

      // R9 disable cancels run in progress
      wr(A_CTL, 32'h5);
      idle(1);
      wr(A_CTL, 32'h0);
      wr(A_CTL, 32'h1);
      idle(12);
      expect_reg(A_STAT, 32'h0, "R9 run cancelled");

      // R4/R7 single run, P=2, R=3: wrap at 16 cycles
      wr(A_CTL, 32'h0);
      wr(A_CFG, 32'h400);
      expect_reg(A_CFG, 32'h400, "R4 config readback");
      wr(A_CTL, 32'h1);
      wr(A_RLD, 32'h3);
      wr(A_CLR, 32'h1A);
      wr(A_CTL, 32'h3);
      idle(14);
      expect_reg(A_STAT, 32'h0, "R4 before divided wrap");
      expect_reg(A_STAT, 32'h2, "R7 single wrap");
      wr(A_CLR, 32'h2);
      idle(60);
      expect_reg(A_STAT, 32'h0, "R7 single run stopped");
      expect_reg(A_CTL, 32'h1, "R7 enable remains");

      // R4 maximum divider, P=7, R=1: wrap at 256 cycles
      wr(A_CTL, 32'h0);
      wr(A_CFG, 32'hE00);
      wr(A_CTL, 32'h1);
      wr(A_RLD, 32'h1);
      wr(A_CLR, 32'h1A);
      wr(A_CTL, 32'h5);
      idle(254);
      expect_reg(A_STAT, 32'h0, "R4 max divider before wrap");
      expect_reg(A_STAT, 32'h2, "R4 max divider wrap");

      // R8 both start bits: looping, R=4 P=0
      wr(A_CTL, 32'h0);
      wr(A_CFG, 32'h0);
      wr(A_CLR, 32'h2);
      wr(A_CTL, 32'h1);
      wr(A_RLD, 32'h4);
      wr(A_CLR, 32'h10);
      wr(A_CTL, 32'h7);
      idle(3);
      expect_reg(A_STAT, 32'h0, "R8 before wrap");
      expect_reg(A_STAT, 32'h2, "R8 first wrap");
      wr(A_CLR, 32'h2);
      expect_reg(A_STAT, 32'h0, "R8 flag cleared");
      idle(1);
      expect_reg(A_STAT, 32'h2, "R8 loops again");

      // R11 masked interrupt, flag still sets
      wr(A_CTL, 32'h0);
      wr(A_CLR, 32'h2);
      wr(A_IEN, 32'h0);
      expect_reg(A_IEN, 32'h0, "R2 cleared while off");
      wr(A_CTL, 32'h5);
      idle(8);
      expect_reg(A_STAT, 32'h2, "R11 flag with irq masked");
      expect_irq(1'b0, "R11 irq masked");
      wr(A_CTL, 32'h0);
      wr(A_IEN, 32'h2);
      expect_irq(1'b1, "R11 irq after unmask with pending flag");

      idle(3);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule